// File: doc/BRIEF.md
# Real-Time Clock Rate Divider

This block turns a 32.768 kHz clock enable (one-cycle pulse per oscillator period, sampled in the system clock domain) into the one-second update tick of a real-time clock. The same ripple of divider bits feeds a 16-way rate selector. The selected bit drives a square-wave pin and a periodic-event strobe.

A three-bit mode field runs the divider, holds it at its mid-count preset, or freezes it. One mode also unlocks a fast-output enable bit. With that bit set, the square-wave pin carries the raw input clock enable instead of a divided tap. A pre-update flag rises a fixed number of input periods before every one-second tick, so software can avoid reading time bytes while they change.

Top module: `rtc_rate_divider`

## Requirements
- R1: After reset, `sqw`, `sec_tick`, `per_strobe`, `pre_update` and `fast_en` are all 0, and the divider sits at its mid-count preset.
- R2: When `osc_mode` goes from a hold value to 010 or 011, the first `sec_tick` follows exactly 16384 input ticks later. Each `sec_tick` is a one-cycle pulse in the cycle after the input tick that completes the count.
- R3: The rate code `rate_sel` picks the square-wave frequency. Code c in 3..15 gives 65536/2^c Hz (3 = 8192 Hz, 15 = 2 Hz). Codes 1 and 2 give 256 Hz and 128 Hz, the same taps as codes 8 and 9. Code 0 gives a constant 0.
- R4: `per_strobe` is a one-cycle pulse in the cycle after each input tick on which the selected tap goes from 0 to 1. Counted from release, the strobes fall at input ticks 2^t + k*2^(t+1), where t = c-2 for c >= 3 and t = c+5 for c in 1..2. Code 0 produces no strobe.
- R5: While `sqw_en` is 0, `sqw` is 0.
- R6: With `osc_mode` = 11x, the divider is held at its mid-count preset: no `sec_tick`, no `per_strobe`, and `sqw` shows the tap value of the preset.
- R7: With `osc_mode` equal to 000, 001, 100 or 101, the divider is frozen: no `sec_tick`, no `per_strobe`, and `sqw` keeps its level.
- R8: A write (`fast_wr`) loads `fast_wdata` into `fast_en` only while `osc_mode` is 011. One cycle after `osc_mode` holds any other value, `fast_en` reads 0.
- R9: While `sqw_en`, `fast_en` and `osc_mode` = 011 are all true, `sqw` equals `osc_tick`. The periodic strobe timing in mode 011 is the same as in mode 010.
- R10: In a running mode, `pre_update` is 1 during the last 8 input ticks before each `sec_tick` (from tick 16376 through 16383 after release) and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | 32.768 kHz clock enable, one cycle wide |
| osc_mode | input | 3 | 010/011 run, 11x hold at preset, others freeze |
| rate_sel | input | 4 | Rate code for square wave and periodic strobe |
| sqw_en | input | 1 | Square-wave output enable |
| fast_wr | input | 1 | Write strobe for the fast-output enable bit |
| fast_wdata | input | 1 | Value written to the fast-output enable bit |
| sqw | output | 1 | Square-wave output |
| sec_tick | output | 1 | One-cycle update tick, once per second |
| per_strobe | output | 1 | One-cycle periodic-event strobe |
| pre_update | output | 1 | High during the 8 input ticks before an update |
| fast_en | output | 1 | Current fast-output enable bit |

## Verification
The periodic strobe is driven through a fast tap (code 3), a mid tap through both of its codes (8 and then 1, with no gap in the strobe train), and the slowest tap (code 15). This separates a correct tap map from an off-by-one or a missing alias. The first update tick and the pre-update window are timed from a release out of hold, which exposes a wrong preset or a wrong window length. Freeze, hold and the raw-clock mode are each entered with a strobing rate selected, so a leak of tick or strobe through a non-running mode shows up as an unexpected item. The fast-enable bit is written under the allowed mode and under a refused mode.

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider #(
  parameter int CNT_W     = 15,
  parameter int PRE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [2:0] osc_mode,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       fast_wr,
  input  logic       fast_wdata,
  output logic       sqw,
  output logic       sec_tick,
  output logic       per_strobe,
  output logic       pre_update,
  output logic       fast_en
);
  localparam int FULL = 1 << CNT_W;
  localparam logic [CNT_W-1:0] HALF      = CNT_W'(FULL / 2);
  localparam logic [CNT_W-1:0] PRE_START = CNT_W'(FULL - PRE_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [3:0]       tap_idx;
  logic             tap_ok, tap_now, tap_rise;
  logic             run, hold, fast_mode;

  assign run       = (osc_mode[2:1] == 2'b01);
  assign hold      = (osc_mode[2:1] == 2'b11);
  assign fast_mode = (osc_mode == 3'b011);
  assign cnt_nxt   = cnt + 1'b1;

  // codes 1 and 2 alias the 256 Hz and 128 Hz taps
  assign tap_ok   = (rate_sel != 4'd0);
  assign tap_idx  = (rate_sel < 4'd3) ? rate_sel + 4'd5 : rate_sel - 4'd2;
  assign tap_now  = tap_ok & cnt[tap_idx];
  assign tap_rise = tap_ok & cnt_nxt[tap_idx] & ~cnt[tap_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= HALF;
      sec_tick   <= 1'b0;
      per_strobe <= 1'b0;
    end else begin
      sec_tick   <= 1'b0;
      per_strobe <= 1'b0;
      if (hold) begin
        cnt <= HALF;
      end else if (run && osc_tick) begin
        cnt        <= cnt_nxt;
        sec_tick   <= &cnt;
        per_strobe <= tap_rise;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          fast_en <= 1'b0;
    else if (!fast_mode) fast_en <= 1'b0;
    else if (fast_wr)    fast_en <= fast_wdata;
  end

  assign sqw        = !sqw_en ? 1'b0 : ((fast_mode && fast_en) ? osc_tick : tap_now);
  assign pre_update = run && (cnt >= PRE_START);

  assert_tick_after_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(pre_update));
  assert_strobe_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_strobe |-> $past(osc_tick) && $past(rate_sel != 4'd0));
  assert_hold_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(osc_mode[2:1] == 2'b11) |-> !sec_tick && !per_strobe);
  assert_freeze_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(osc_mode[1] == 1'b0) |-> !sec_tick && !per_strobe);
  assert_fast_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(osc_mode != 3'b011) |-> !fast_en);
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

// File: tb/rtc_rate_divider_bench.sv
`timescale 1ns/1ps
module rtc_rate_divider_bench;
  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0;
  logic [2:0] osc_mode = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic sqw_en = 1'b0, fast_wr = 1'b0, fast_wdata = 1'b0;
  logic sqw, sec_tick, per_strobe, pre_update, fast_en;

  rtc_rate_divider u_rtc_rate_divider (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_mode(osc_mode),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .fast_wr(fast_wr), .fast_wdata(fast_wdata),
    .sqw(sqw), .sec_tick(sec_tick), .per_strobe(per_strobe),
    .pre_update(pre_update), .fast_en(fast_en));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  int ticks_done = 0, base = 0, strobes_seen = 0, secs_seen = 0;
  bit gate = 1'b0, finished = 1'b0;
  int strobe_q[$];
  int sec_q[$];

  // monitor: counts consumed input ticks, pops expected strobes/ticks
  always @(negedge clk) begin
    if (osc_tick) ticks_done++;
    if (per_strobe) begin
      strobes_seen++;
      compared++;
      if (strobe_q.size() == 0) begin
        mismatched++;
        $display("FAIL R4 unexpected strobe at tick %0d expected none", ticks_done - base);
      end else begin
        int e;
        e = strobe_q.pop_front();
        if (e != ticks_done) begin
          mismatched++;
          $display("FAIL R4 strobe at tick %0d expected %0d", ticks_done - base, e - base);
        end
      end
    end
    if (sec_tick) begin
      secs_seen++;
      compared++;
      if (sec_q.size() == 0) begin
        mismatched++;
        $display("FAIL R2 unexpected update tick at %0d expected none", ticks_done - base);
      end else begin
        int e;
        e = sec_q.pop_front();
        if (e != ticks_done) begin
          mismatched++;
          $display("FAIL R2 update tick at %0d expected %0d", ticks_done - base, e - base);
        end
      end
    end
    osc_tick <= gate ? ~osc_tick : 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wait_to(input int n);
    while (ticks_done - base < n) step();
  endtask

  task automatic push_strobes(input int t, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) strobe_q.push_back(base + (1 << t) + k * (1 << (t + 1)));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s0, s1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(sqw == 0 && sec_tick == 0 && per_strobe == 0, "R1", "outputs after reset", {sqw, sec_tick, per_strobe}, 0);
    check(pre_update == 0 && fast_en == 0, "R1", "flags after reset", {pre_update, fast_en}, 0);

    // R6 hold with a strobing rate
    osc_mode = 3'b110; rate_sel = 4'd3; sqw_en = 1'b1; gate = 1'b1;
    s0 = strobes_seen;
    wait_to(60);
    check(strobes_seen == s0 && secs_seen == 0, "R6", "events in hold", strobes_seen - s0, 0);
    check(sqw == 0, "R6", "sqw at preset (code 3)", sqw, 0);

    // release: R2, R3, R4, R10
    osc_mode = 3'b010; base = ticks_done;
    push_strobes(1, 0, 9);
    sec_q.push_back(base + 16384);
    wait_to(2);  check(sqw == 1, "R3", "code 3 tap high at tick 2", sqw, 1);
    wait_to(4);  check(sqw == 0, "R3", "code 3 tap low at tick 4", sqw, 0);
    wait_to(40); rate_sel = 4'd8; push_strobes(6, 0, 7);
    wait_to(100); check(sqw == 1, "R3", "code 8 tap high at tick 100", sqw, 1);
    wait_to(130); check(sqw == 0, "R3", "code 8 tap low at tick 130", sqw, 0);
    wait_to(1000); rate_sel = 4'd1; push_strobes(6, 8, 15);
    wait_to(2000); rate_sel = 4'd15; push_strobes(13, 0, 1);
    check(strobe_q.size() == 2, "R3", "alias code 1 strobes consumed", strobe_q.size(), 2);
    wait_to(16375); check(pre_update == 0, "R10", "window before start", pre_update, 0);
    wait_to(16376); check(pre_update == 1, "R10", "window first tick", pre_update, 1);
    wait_to(16383); check(pre_update == 1, "R10", "window last tick", pre_update, 1);
    wait_to(16384); check(pre_update == 0, "R10", "window after update", pre_update, 0);
    step();
    check(secs_seen == 1, "R2", "first update seen", secs_seen, 1);
    wait_to(24600);
    check(strobe_q.size() == 0, "R4", "code 15 strobes consumed", strobe_q.size(), 0);
    sqw_en = 1'b0; step();
    check(sqw == 0, "R5", "sqw with enable off and tap high", sqw, 0);

    // R7 freeze
    rate_sel = 4'd3; sqw_en = 1'b1; osc_mode = 3'b000; step();
    s0 = sqw; s1 = strobes_seen; base = ticks_done;
    wait_to(50);
    check(strobes_seen == s1, "R7", "strobes while frozen", strobes_seen - s1, 0);
    check(sqw == s0, "R7", "sqw level while frozen", sqw, s0);
    fast_wr = 1'b1; fast_wdata = 1'b1; step(); fast_wr = 1'b0; step();
    check(fast_en == 0, "R8", "write refused outside mode 011", fast_en, 0);

    // R9 raw path in mode 011
    osc_mode = 3'b110; base = ticks_done; wait_to(10);
    osc_mode = 3'b011; rate_sel = 4'd4; base = ticks_done;
    push_strobes(2, 0, 7);
    fast_wr = 1'b1; fast_wdata = 1'b1; step(); fast_wr = 1'b0;
    check(fast_en == 1, "R8", "write accepted in mode 011", fast_en, 1);
    check(sqw == osc_tick, "R9", "sqw follows raw input", sqw, osc_tick);
    step();
    check(sqw == osc_tick, "R9", "sqw follows raw input next cycle", sqw, osc_tick);
    wait_to(64); rate_sel = 4'd0;
    check(strobe_q.size() == 0, "R9", "strobe timing in mode 011", strobe_q.size(), 0);
    osc_mode = 3'b010; step();
    check(fast_en == 0, "R8", "cleared after leaving 011", fast_en, 0);
    check(sqw == 0, "R3", "code 0 gives constant low", sqw, 0);
    s1 = strobes_seen; wait_to(200);
    check(strobes_seen == s1, "R4", "code 0 gives no strobes", strobes_seen - s1, 0);
    check(sec_q.size() == 0, "R2", "expected update ticks consumed", sec_q.size(), 0);
    summary();
  end
endmodule